// File: doc/BRIEF.md
# Master Address Decoder with Boot Alias and Remap

This block turns the 32-bit address issued by one bus master into a one-hot select for the slave that owns that address, or into an abort flag when nothing lives there. The decode happens in two steps. The top four address bits pick one of sixteen 256 MB banks. Inside bank 0, which holds the on-chip memories, the next eight bits pick one of 256 regions of 1 MB each.

Region 0 of bank 0 is an alias, because the processor always starts fetching at address zero. Before remap, the alias points at the on-chip boot ROM or at the external bus. The choice comes from a boot-mode pin that is captured while reset is held. Once software has booted it writes the remap bit, and from then on the alias points at the main on-chip SRAM. Every other memory stays reachable at its own fixed address whatever the state of the alias.

The address-to-select path is purely combinational. Only the captured boot mode and the remap bit are registered.

Top module: `addr_decoder`

## Requirements
- R1: `slv_sel` encoding: bit 0 is the boot ROM, bit 1 the main SRAM, bit 2 the auxiliary RAM, bit 3 the external bus and bit 4 the peripheral space. Any address whose bits [31:28] lie between 1 and 8 inclusive selects bit 3 (external bus), whatever its low bits.
- R2: Any address with bits [31:28] equal to 15 selects bit 4 (peripherals).
- R3: Any address with bits [31:28] from 9 to 14 asserts `abort` and drives `slv_sel` to zero.
- R4: Inside bank 0, bits [27:20] select the region. Region 1 always selects the boot ROM, region 2 the main SRAM and region 3 the auxiliary RAM, regardless of boot mode and remap.
- R5: Inside bank 0, regions 4 to 255 assert `abort` and drive `slv_sel` to zero.
- R6: With the remap bit clear, region 0 of bank 0 selects the boot ROM when the captured boot mode is 0, and the external bus when it is 1.
- R7: With the remap bit set, region 0 of bank 0 selects the main SRAM, whatever the captured boot mode.
- R8: Reset clears the remap bit. A cycle with `remap_we` high loads `remap_wd` into it. The new value steers the alias from the following clock cycle onward, and without a write the bit holds its value.
- R9: The boot mode is the value of `boot_pin` at the last clock edge with `rst_n` low. Changes of `boot_pin` after reset release have no effect on the decode.
- R10: Exactly one of the six signals {`abort`, `slv_sel[4:0]`} is high for every address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the boot-mode and remap registers |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_pin | input | 1 | Boot-mode strap, captured during reset (1 = external boot) |
| remap_we | input | 1 | Write strobe for the remap bit |
| remap_wd | input | 1 | Value written to the remap bit |
| addr | input | 32 | Master address to decode |
| slv_sel | output | 5 | One-hot slave select |
| abort | output | 1 | Access targets an unmapped region |

## Verification
The only internal state is the captured boot mode and the remap bit. If either is wrong, the error shows only on addresses inside the 1 MB alias at zero: that address range reports the wrong one of three slaves, while every fixed region decodes as before. A remap write is visible on the alias one clock after the strobe, so a stale or early update is caught by probing address zero in the cycle of the write and in the cycle after it. A boot-pin change after reset release is probed at once. Errors in the decode tables appear in the same cycle as the address, so the bench walks every region boundary and bank boundary, and adds random addresses that are weighted towards bank 0.

// File: rtl/addr_dec_pkg.sv
// Shared types for the master address decoder.
// Assumes five slaves in a fixed one-hot order that the bench relies on.
package addr_dec_pkg;

    localparam int NSLV     = 5;
    localparam int SLV_ROM  = 0;
    localparam int SLV_SRAM = 1;
    localparam int SLV_AUX  = 2;
    localparam int SLV_EXT  = 3;
    localparam int SLV_PER  = 4;

    typedef logic [NSLV-1:0] slv_vec_t;

    typedef enum logic [1:0] {
        BK_INTERNAL,
        BK_EXTERNAL,
        BK_PERIPH,
        BK_HOLE
    } bank_kind_e;

    // Build a one-hot select with the given slave index set.
    function automatic slv_vec_t slv_onehot(input int idx);
        slv_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/boot_ctl.sv
// Boot-mode capture and remap register.
// The boot strap is followed while reset is low and frozen once reset is released.
// The remap bit clears on reset and is loaded by a single-cycle write strobe.
module boot_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic boot_pin,
    input  logic remap_we,
    input  logic remap_wd,
    output logic boot_ext,
    output logic remapped
);

    // Capture the strap during reset and update the remap bit on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_ext <= boot_pin;
            remapped <= 1'b0;
        end else if (remap_we) begin
            remapped <= remap_wd;
        end
    end

    // R9
    boot_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(boot_ext));

    // R8
    remap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remap_we |=> (remapped == $past(remap_wd)));

    // R8
    remap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !remap_we |=> $stable(remapped));

endmodule

// File: rtl/bank_decode.sv
// First-level decode: classifies a bank number as internal, external, peripheral or hole.
// Assumes bank 0 is internal and the external banks form one contiguous range.
module bank_decode
    import addr_dec_pkg::*;
#(
    parameter int BANK_BITS   = 4,
    parameter int EXT_FIRST   = 1,
    parameter int EXT_LAST    = 8,
    parameter int PERIPH_BANK = 15
) (
    input  logic [BANK_BITS-1:0] bank,
    output bank_kind_e           kind
);

    localparam int NBANK = 1 << BANK_BITS;

    logic [NBANK-1:0] ext_mask;

    // One mask bit per bank marks the external bus range.
    for (genvar b = 0; b < NBANK; b++) begin : g_ext
        assign ext_mask[b] = (b >= EXT_FIRST) && (b <= EXT_LAST);
    end

    // Classify the bank, with internal first and unmapped as the fallback.
    always_comb begin
        if (bank == '0)
            kind = BK_INTERNAL;
        else if (ext_mask[bank])
            kind = BK_EXTERNAL;
        else if (bank == BANK_BITS'(PERIPH_BANK))
            kind = BK_PERIPH;
        else
            kind = BK_HOLE;
    end

endmodule

// File: rtl/int_decode.sv
// Second-level decode inside the internal bank.
// Region 0 is the boot alias; three fixed regions map one memory each; the rest is a hole.
module int_decode
    import addr_dec_pkg::*;
#(
    parameter int REGION_BITS = 8,
    parameter int ROM_REGION  = 1,
    parameter int SRAM_REGION = 2,
    parameter int AUX_REGION  = 3
) (
    input  logic [REGION_BITS-1:0] region,
    input  logic                   boot_ext,
    input  logic                   remapped,
    output slv_vec_t               sel,
    output logic                   hole
);

    slv_vec_t alias_sel;

    // The remap bit wins over the boot mode for the alias target.
    always_comb begin
        if (remapped)
            alias_sel = slv_onehot(SLV_SRAM);
        else if (boot_ext)
            alias_sel = slv_onehot(SLV_EXT);
        else
            alias_sel = slv_onehot(SLV_ROM);
    end

    // Map the region index to a slave, or flag it as unmapped.
    always_comb begin
        sel  = '0;
        hole = 1'b0;
        if (region == '0)
            sel = alias_sel;
        else if (region == REGION_BITS'(ROM_REGION))
            sel = slv_onehot(SLV_ROM);
        else if (region == REGION_BITS'(SRAM_REGION))
            sel = slv_onehot(SLV_SRAM);
        else if (region == REGION_BITS'(AUX_REGION))
            sel = slv_onehot(SLV_AUX);
        else
            hole = 1'b1;
    end

endmodule

// File: rtl/addr_decoder.sv
// Address decoder for one bus master: bank decode, internal sub-decode and boot alias.
// Assumes the address is stable while it is sampled; the select path has no registers.
module addr_decoder
    import addr_dec_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int BANK_BITS    = 4,
    parameter int REGION_SHIFT = 20,
    parameter int EXT_FIRST    = 1,
    parameter int EXT_LAST     = 8,
    parameter int PERIPH_BANK  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_pin,
    input  logic              remap_we,
    input  logic              remap_wd,
    input  logic [ADDR_W-1:0] addr,
    output logic [NSLV-1:0]   slv_sel,
    output logic              abort
);

    localparam int BANK_LSB    = ADDR_W - BANK_BITS;
    localparam int REGION_BITS = BANK_LSB - REGION_SHIFT;

    logic [BANK_BITS-1:0]   bank;
    logic [REGION_BITS-1:0] region;
    logic                   unused_low;
    logic                   boot_ext;
    logic                   remapped;
    bank_kind_e             kind;
    slv_vec_t               int_sel;
    logic                   int_hole;

    assign bank       = addr[ADDR_W-1:BANK_LSB];
    assign region     = addr[BANK_LSB-1:REGION_SHIFT];
    assign unused_low = ^addr[REGION_SHIFT-1:0];

    boot_ctl u_boot (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_pin (boot_pin),
        .remap_we (remap_we),
        .remap_wd (remap_wd),
        .boot_ext (boot_ext),
        .remapped (remapped)
    );

    bank_decode #(
        .BANK_BITS   (BANK_BITS),
        .EXT_FIRST   (EXT_FIRST),
        .EXT_LAST    (EXT_LAST),
        .PERIPH_BANK (PERIPH_BANK)
    ) u_bank (
        .bank (bank),
        .kind (kind)
    );

    int_decode #(
        .REGION_BITS (REGION_BITS)
    ) u_int (
        .region   (region),
        .boot_ext (boot_ext),
        .remapped (remapped),
        .sel      (int_sel),
        .hole     (int_hole)
    );

    // Merge the bank class with the internal sub-decode.
    always_comb begin
        slv_sel = '0;
        abort   = 1'b0;
        unique case (kind)
            BK_INTERNAL: begin
                slv_sel = int_sel;
                abort   = int_hole;
            end
            BK_EXTERNAL: slv_sel = slv_onehot(SLV_EXT);
            BK_PERIPH:   slv_sel = slv_onehot(SLV_PER);
            default:     abort   = 1'b1;
        endcase
    end

    // R10
    decode_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({abort, slv_sel}) == 1);

    // R1
    ext_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bank) >= EXT_FIRST && int'(bank) <= EXT_LAST) |-> slv_sel[SLV_EXT]);

    // R3
    hole_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bank) > EXT_LAST && int'(bank) != PERIPH_BANK) |-> (abort && slv_sel == '0));

    // R7
    remap_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank == '0 && region == '0 && remapped) |-> slv_sel[SLV_SRAM]);

endmodule

// File: tb/tb_addr_decoder.sv
module tb_addr_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_pin = 1'b0;
    logic        remap_we = 1'b0;
    logic        remap_wd = 1'b0;
    logic [31:0] addr = '0;
    logic [4:0]  slv_sel;
    logic        abort;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic exp_boot = 1'b0;
    logic exp_rm   = 1'b0;

    always #2 clk = ~clk;

    addr_decoder dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_pin (boot_pin),
        .remap_we (remap_we),
        .remap_wd (remap_wd),
        .addr     (addr),
        .slv_sel  (slv_sel),
        .abort    (abort)
    );

    // Expected {abort, slv_sel} from the address map in the requirements.
    function automatic logic [5:0] model(input logic [31:0] a, input logic bt, input logic rm);
        logic [3:0] bank;
        logic [7:0] reg_i;
        bank  = a[31:28];
        reg_i = a[27:20];
        if (bank == 4'd0) begin
            if (reg_i == 8'd0) return rm ? 6'b000010 : (bt ? 6'b001000 : 6'b000001);
            if (reg_i == 8'd1) return 6'b000001;
            if (reg_i == 8'd2) return 6'b000010;
            if (reg_i == 8'd3) return 6'b000100;
            return 6'b100000;
        end
        if (bank <= 4'd8) return 6'b001000;
        if (bank == 4'd15) return 6'b010000;
        return 6'b100000;
    endfunction

    function automatic string req_of(input logic [31:0] a, input logic rm);
        if (a[31:28] == 4'd0) begin
            if (a[27:20] == 8'd0) return rm ? "R7" : "R6";
            if (a[27:20] <= 8'd3) return "R4";
            return "R5";
        end
        if (a[31:28] <= 4'd8) return "R1";
        if (a[31:28] == 4'd15) return "R2";
        return "R3";
    endfunction

    task automatic compare(input logic [31:0] a, input string req);
        logic [5:0] exp;
        logic [5:0] act;
        exp = model(a, exp_boot, exp_rm);
        act = {abort, slv_sel};
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%b expected=%b", req, a, act, exp);
        end
        tests++;
        if ($countones(act) != 1) begin
            fails++;
            $display("FAIL R10 addr=%h actual=%b expected=one bit set", a, act);
        end
    endtask

    task automatic probe(input logic [31:0] a, input string req);
        @(negedge clk);
        addr = a;
        #1;
        compare(a, req);
    endtask

    task automatic probe_rand(input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] a;
            a = $urandom();
            if (i % 2 == 0) a[31:28] = 4'd0;
            if (i % 4 == 0) a[27:22] = 6'd0;
            probe(a, req_of(a, exp_rm));
        end
    endtask

    task automatic probe_bounds();
        logic [31:0] pts [14];
        pts = '{32'h0000_0000, 32'h000F_FFFF, 32'h0010_0000, 32'h001F_FFFF,
                32'h0020_0000, 32'h002F_FFFF, 32'h0030_0000, 32'h003F_FFFF,
                32'h0040_0000, 32'h0FFF_FFFF, 32'h1000_0000, 32'h8FFF_FFFF,
                32'h9000_0000, 32'hF000_0000};
        for (int i = 0; i < 14; i++) probe(pts[i], req_of(pts[i], exp_rm));
        probe(32'hEFFF_FFFF, "R3");
        probe(32'hFFFF_FFFF, "R2");
    endtask

    // Write the remap bit; the alias must not move in the write cycle itself.
    task automatic write_remap(input logic v);
        @(negedge clk);
        remap_we = 1'b1;
        remap_wd = v;
        addr     = 32'h0000_0000;
        #1;
        compare(32'h0000_0000, "R8");
        @(negedge clk);
        remap_we = 1'b0;
        remap_wd = ~v;
        exp_rm   = v;
        #1;
        compare(32'h0000_0000, "R8");
    endtask

    // Hold reset with a strap value that changes just before release.
    task automatic do_reset(input logic early, input logic last);
        @(negedge clk);
        rst_n    = 1'b0;
        boot_pin = early;
        repeat (3) @(negedge clk);
        boot_pin = last;
        @(negedge clk);
        rst_n    = 1'b1;
        boot_pin = ~last;
        exp_boot = last;
        exp_rm   = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1357));
        // R9: strap 1 early in reset, 0 at the last reset edge, 1 after release
        do_reset(1'b1, 1'b0);
        probe(32'h0000_0000, "R9");
        probe(32'h0008_1234, "R8");
        probe_bounds();
        probe_rand(400);
        write_remap(1'b1);
        probe(32'h000A_BCDE, "R7");
        probe_bounds();
        probe_rand(400);
        write_remap(1'b0);
        probe(32'h0000_0010, "R6");
        // R9: external boot captured, strap dropped after release
        do_reset(1'b0, 1'b1);
        probe(32'h0000_0000, "R9");
        probe(32'h000F_0000, "R6");
        probe_bounds();
        probe_rand(300);
        write_remap(1'b1);
        probe(32'h0000_0004, "R7");
        probe(32'h0010_0000, "R4");
        probe_rand(300);
        // R8: reset clears the remap bit again
        do_reset(1'b1, 1'b1);
        probe(32'h0000_0000, "R8");
        finish_run();
    end

endmodule